// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

A direct-mapped, one-word-per-line data cache that keeps one processor coherent with a shared single-cycle bus by the write-once policy. Each line holds one of four states: Invalid, Valid (clean copy), Reserved (written exactly once, with that write already in memory) and Dirty (written more than once, memory stale). The first processor write to a clean line goes through to memory, and every other cache drops its copy. Later writes stay local. A Dirty line is written back only when it is evicted or when another master reads it.

The controller keeps two copies of the tag and state arrays and always writes them together. One copy serves processor lookups. The other watches every bus transfer started by another master and responds in the same cycle. If that other master reads a Dirty line, the controller raises an inhibit output and drives the line itself. Memory is expected to take that data on the same bus cycle. Masters without a cache can share the bus unchanged.

The processor holds `cpu_req` with its command until `cpu_done` pulses. The bus arbiter answers `bus_req` with `bus_gnt`, and the transfer is the one cycle in which both are high.

Top module: `wo_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, `cpu_done`, `bus_req` and `snp_inhibit` are low, and the first read of any address makes a bus read.
- R2: A read miss makes exactly one bus read and installs the word as Valid. The word comes back on `cpu_rdata` with `cpu_done`. A read hit returns the stored word with no bus transfer, and `cpu_done` lasts one cycle.
- R3: A write that hits a Valid line makes one bus write of that word to that address, and the line becomes Reserved. `cpu_done` rises the cycle after the bus write.
- R4: A write that hits a Reserved or Dirty line makes no bus transfer and leaves the line Dirty. Later reads return the newest word.
- R5: On a miss, a Dirty line at the same index is first written back with one bus write of its own address and data, then the fill read follows. A Valid or Reserved line at that index is replaced with no bus write.
- R6: A write miss does the fill read, with a write-back first if needed, and then the write-through of R3. That is two bus transfers when the victim is clean.
- R7: A bus write by another master that hits a line makes it Invalid, so the next processor access to it misses.
- R8: A bus read by another master that hits a Valid line changes nothing. One that hits a Reserved line makes it Valid, so the next processor write to it goes through on the bus again.
- R9: A bus read by another master that hits a Dirty line raises `snp_inhibit` in that same cycle with the line's word on `snp_data`. The line becomes Valid: a repeat read is not inhibited and returns the same word from memory.
- R10: Transfers the cache itself makes (`bus_gnt` high) are never snooped. Its own write-through does not invalidate its own line.
- R11: If a snoop hits the index the processor is requesting in the same cycle, the snoop is applied first. The processor request is then evaluated against the updated state: a write to a line that was just invalidated performs a fill and then a write-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write word |
| cpu_rdata | output | DW | Read word, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Request for the bus |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_valid | output | 1 | This cache's transfer is on the bus |
| bus_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | AW | Transfer address |
| bus_wdata | output | DW | Transfer write word |
| bus_rdata | input | DW | Read word from memory or an inhibiting cache |
| snp_valid | input | 1 | A transfer is on the shared bus |
| snp_we | input | 1 | Shared bus transfer is a write |
| snp_addr | input | AW | Shared bus address |
| snp_inhibit | output | 1 | Memory must not answer; this cache supplies |
| snp_data | output | DW | Word supplied while inhibiting |

## Verification
A snoop from another master and a processor lookup can land on the same index in the same cycle. That is the case where a line is changed under a request that has already been issued. The bench forces it by having an uncached master write a line in exactly the cycle the processor asks to write that line, which is already Valid. The result is judged at the ports. The cache must now make two bus transfers (a fill and then a write-through) instead of the one a Valid hit needs, and a later uncached read must return the processor's word without any inhibit. A second cache on the same memory model checks that invalidations and clean-downs propagate between caches.

// File: rtl/wo_snoop_cache.sv
module wo_snoop_cache #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_done,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_valid,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  logic          snp_we,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_inhibit,
  output logic [DW-1:0] snp_data
);
  localparam int TW = AW - IW;
  localparam int NS = 1 << IW;

  typedef enum logic [1:0] {L_INV, L_VAL, L_RSV, L_DRT} line_t;
  typedef enum logic [1:0] {F_IDLE, F_WB, F_FILL, F_WT} fsm_t;

  fsm_t            fsm;
  logic [TW-1:0]   tag_c [NS];
  logic [TW-1:0]   tag_s [NS];
  line_t           st_c  [NS];
  line_t           st_s  [NS];
  logic [DW-1:0]   dat   [NS];

  wire [IW-1:0] cidx = cpu_addr[IW-1:0];
  wire [TW-1:0] ctag = cpu_addr[AW-1:IW];
  wire [IW-1:0] sidx = snp_addr[IW-1:0];
  wire [TW-1:0] stag = snp_addr[AW-1:IW];

  line_t c_st, s_st;
  assign c_st = st_c[cidx];
  assign s_st = st_s[sidx];

  wire c_hit  = (c_st != L_INV) && (tag_c[cidx] == ctag);
  wire s_hit  = snp_valid && !bus_gnt && (s_st != L_INV) && (tag_s[sidx] == stag);
  wire clash  = s_hit && (sidx == cidx);
  wire go     = (fsm == F_IDLE) && cpu_req && !cpu_done && !clash;
  wire v_dirty = (c_st == L_DRT);
  wire wt_ok  = c_hit && (c_st == L_VAL);

  assign snp_inhibit = s_hit && !snp_we && (s_st == L_DRT);
  assign snp_data    = dat[sidx];

  assign bus_req   = ((fsm == F_WB) && v_dirty) || (fsm == F_FILL) || ((fsm == F_WT) && wt_ok);
  assign bus_valid = bus_req && bus_gnt;
  assign bus_we    = (fsm != F_FILL);
  assign bus_addr  = (fsm == F_WB) ? {tag_c[cidx], cidx} : cpu_addr;
  assign bus_wdata = (fsm == F_WB) ? dat[cidx] : cpu_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm       <= F_IDLE;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      for (int i = 0; i < NS; i++) begin
        st_c[i]  <= L_INV;
        st_s[i]  <= L_INV;
        tag_c[i] <= '0;
        tag_s[i] <= '0;
      end
    end else begin
      cpu_done <= 1'b0;
      case (fsm)
        F_IDLE: if (go) begin
          if (c_hit) begin
            if (!cpu_we) begin
              cpu_rdata <= dat[cidx];
              cpu_done  <= 1'b1;
            end else if (c_st == L_VAL) begin
              fsm <= F_WT;
            end else begin
              dat[cidx]  <= cpu_wdata;
              st_c[cidx] <= L_DRT;
              st_s[cidx] <= L_DRT;
              cpu_done   <= 1'b1;
            end
          end else begin
            fsm <= v_dirty ? F_WB : F_FILL;
          end
        end
        F_WB: begin
          if (!v_dirty) fsm <= F_FILL;
          else if (bus_gnt) begin
            st_c[cidx] <= L_VAL;
            st_s[cidx] <= L_VAL;
            fsm        <= F_FILL;
          end
        end
        F_FILL: if (bus_gnt) begin
          tag_c[cidx] <= ctag;
          tag_s[cidx] <= ctag;
          st_c[cidx]  <= L_VAL;
          st_s[cidx]  <= L_VAL;
          dat[cidx]   <= bus_rdata;
          fsm         <= F_IDLE;
        end
        F_WT: begin
          if (!wt_ok) fsm <= F_IDLE;
          else if (bus_gnt) begin
            dat[cidx]  <= cpu_wdata;
            st_c[cidx] <= L_RSV;
            st_s[cidx] <= L_RSV;
            cpu_done   <= 1'b1;
            fsm        <= F_IDLE;
          end
        end
        default: fsm <= F_IDLE;
      endcase
      if (s_hit) begin
        if (snp_we) begin
          st_c[sidx] <= L_INV;
          st_s[sidx] <= L_INV;
        end else if (s_st == L_RSV || s_st == L_DRT) begin
          st_c[sidx] <= L_VAL;
          st_s[sidx] <= L_VAL;
        end
      end
    end
  end

  AST_INH_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inhibit |-> (snp_valid && !snp_we && !bus_gnt)); // R9
  AST_INH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inhibit |=> !(snp_inhibit && snp_addr == $past(snp_addr))); // R9
  AST_INVAL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_we && !bus_gnt) |=> !(snp_inhibit && snp_addr == $past(snp_addr))); // R7
  AST_WT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && cpu_req && cpu_we && bus_addr == cpu_addr && bus_wdata == cpu_wdata) |=> cpu_done); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R2
  AST_COPY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_c[cidx] == st_s[cidx]) && (tag_c[cidx] == tag_s[cidx])); // R7
endmodule

// File: tb/sim_wo_snoop_cache.sv
`timescale 1ns/1ps
module sim_wo_snoop_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;

  logic        c0_req = 0, c0_we = 0, c1_req = 0, c1_we = 0;
  logic [7:0]  c0_a = 0, c1_a = 0;
  logic [15:0] c0_wd = 0, c1_wd = 0;
  logic [15:0] c0_rd, c1_rd;
  logic        c0_dn, c1_dn;
  logic        rq0, rq1, bv0, bv1, bwe0, bwe1, inh0, inh1;
  logic [7:0]  ba0, ba1;
  logic [15:0] bwd0, bwd1, sd0, sd1;

  logic        io_v = 0, io_we = 0;
  logic [7:0]  io_a = 0;
  logic [15:0] io_wd = 0;

  wire gnt0 = rq0 && !io_v;
  wire gnt1 = rq1 && !io_v && !rq0;
  wire        b_valid = io_v || bv0 || bv1;
  wire        b_we    = io_v ? io_we : bv0 ? bwe0 : bwe1;
  wire [7:0]  b_addr  = io_v ? io_a  : bv0 ? ba0  : ba1;
  wire [15:0] b_wdata = io_v ? io_wd : bv0 ? bwd0 : bwd1;

  logic [15:0] mem [256];
  wire [15:0] b_rdata = inh0 ? sd0 : inh1 ? sd1 : mem[b_addr];

  function automatic logic [15:0] mi(input int a);
    return 16'(16'h100 + a * 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) mem[a] <= mi(a);
    end else if (b_valid) begin
      if (b_we) mem[b_addr] <= b_wdata;
      else if (inh0 || inh1) mem[b_addr] <= b_rdata;
    end
  end

  int t0 = 0, w0 = 0, t1 = 0, w1 = 0;
  always @(posedge clk) begin
    if (bv0) begin t0++; if (bwe0) w0++; end
    if (bv1) begin t1++; if (bwe1) w1++; end
  end

  wo_snoop_cache u0 (.clk, .rst_n, .cpu_req(c0_req), .cpu_we(c0_we), .cpu_addr(c0_a),
    .cpu_wdata(c0_wd), .cpu_rdata(c0_rd), .cpu_done(c0_dn), .bus_req(rq0), .bus_gnt(gnt0),
    .bus_valid(bv0), .bus_we(bwe0), .bus_addr(ba0), .bus_wdata(bwd0), .bus_rdata(b_rdata),
    .snp_valid(b_valid), .snp_we(b_we), .snp_addr(b_addr), .snp_inhibit(inh0), .snp_data(sd0));
  wo_snoop_cache u1 (.clk, .rst_n, .cpu_req(c1_req), .cpu_we(c1_we), .cpu_addr(c1_a),
    .cpu_wdata(c1_wd), .cpu_rdata(c1_rd), .cpu_done(c1_dn), .bus_req(rq1), .bus_gnt(gnt1),
    .bus_valid(bv1), .bus_we(bwe1), .bus_addr(ba1), .bus_wdata(bwd1), .bus_rdata(b_rdata),
    .snp_valid(b_valid), .snp_we(b_we), .snp_addr(b_addr), .snp_inhibit(inh1), .snp_data(sd1));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic start_cpu(input int c, input logic we, input logic [7:0] a, input logic [15:0] d);
    t0 = 0; w0 = 0; t1 = 0; w1 = 0;
    if (c == 0) begin c0_req = 1; c0_we = we; c0_a = a; c0_wd = d; end
    else        begin c1_req = 1; c1_we = we; c1_a = a; c1_wd = d; end
  endtask

  task automatic wait_cpu(input int c, output logic [15:0] rd, output int ntx, output int nwr);
    int n = 0;
    do begin @(negedge clk); n++; end
    while (!(c == 0 ? c0_dn : c1_dn) && n < 200);
    if (n >= 200) chk("watchdog", 1, 0);
    rd = (c == 0) ? c0_rd : c1_rd;
    c0_req = 0; c1_req = 0;
    ntx = (c == 0) ? t0 : t1;
    nwr = (c == 0) ? w0 : w1;
  endtask

  task automatic cpu_op(input int c, input logic we, input logic [7:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output int ntx, output int nwr);
    @(negedge clk);
    start_cpu(c, we, a, d);
    wait_cpu(c, rd, ntx, nwr);
  endtask

  task automatic io_op(input logic we, input logic [7:0] a, input logic [15:0] d,
                       output logic [15:0] rd, output logic inh);
    @(negedge clk);
    io_v = 1; io_we = we; io_a = a; io_wd = d;
    #1;
    rd = b_rdata; inh = inh0 || inh1;
    @(negedge clk);
    io_v = 0;
  endtask

  // {we, addr, wdata, expected read word, bus transfers, bus writes, requirement}
  localparam logic [48:0] VEC [14] = '{
    {1'b0, 8'h10, 16'h0000, 16'h0130, 2'd1, 2'd0, 4'd2},  // R2 read miss
    {1'b0, 8'h10, 16'h0000, 16'h0130, 2'd0, 2'd0, 4'd2},  // R2 read hit
    {1'b1, 8'h10, 16'hA001, 16'h0000, 2'd1, 2'd1, 4'd3},  // R3 Valid write goes through
    {1'b1, 8'h10, 16'hA002, 16'h0000, 2'd0, 2'd0, 4'd10}, // R10 own write kept line Reserved
    {1'b1, 8'h10, 16'hA003, 16'h0000, 2'd0, 2'd0, 4'd4},  // R4 Dirty write local
    {1'b0, 8'h10, 16'h0000, 16'hA003, 2'd0, 2'd0, 4'd4},  // R4 newest word
    {1'b0, 8'h14, 16'h0000, 16'h013C, 2'd2, 2'd1, 4'd5},  // R5 Dirty victim written back
    {1'b0, 8'h10, 16'h0000, 16'hA003, 2'd1, 2'd0, 4'd5},  // R5 clean victim, no write
    {1'b1, 8'h21, 16'hB001, 16'h0000, 2'd2, 2'd1, 4'd6},  // R6 write miss
    {1'b0, 8'h21, 16'h0000, 16'hB001, 2'd0, 2'd0, 4'd6},  // R6
    {1'b1, 8'h21, 16'hB002, 16'h0000, 2'd0, 2'd0, 4'd4},  // R4 Reserved to Dirty
    {1'b0, 8'h25, 16'h0000, 16'h016F, 2'd2, 2'd1, 4'd5},  // R5
    {1'b1, 8'h25, 16'hC001, 16'h0000, 2'd1, 2'd1, 4'd3},  // R3
    {1'b0, 8'h21, 16'h0000, 16'hB002, 2'd1, 2'd0, 4'd5}   // R5 Reserved victim, no write
  };

  initial begin : watchdog
    #500000;
    chk("watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic inh;
    int ntx, nwr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done", c0_dn, 0);
    chk("R1 req", rq0, 0);
    chk("R1 inhibit", inh0, 0);

    for (int i = 0; i < 14; i++) begin
      string r;
      r = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      cpu_op(0, VEC[i][48], VEC[i][47:40], VEC[i][39:24], rd, ntx, nwr);
      if (!VEC[i][48]) chk({r, " data"}, rd, VEC[i][23:8]);
      chk({r, " transfers"}, ntx, VEC[i][7:6]);
      chk({r, " writes"}, nwr, VEC[i][5:4]);
    end

    // R7: uncached write invalidates line 0x10
    io_op(1, 8'h10, 16'hD000, rd, inh);
    cpu_op(0, 0, 8'h10, 0, rd, ntx, nwr);
    chk("R7 refetch", ntx, 1);
    chk("R7 data", rd, 16'hD000);

    // R8 / R9
    cpu_op(0, 1, 8'h10, 16'hE001, rd, ntx, nwr);
    chk("R3 through", nwr, 1);
    io_op(0, 8'h10, 0, rd, inh);
    chk("R8 no inhibit on Reserved", inh, 0);
    chk("R8 memory data", rd, 16'hE001);
    cpu_op(0, 1, 8'h10, 16'hE002, rd, ntx, nwr);
    chk("R8 Reserved became Valid", nwr, 1);
    cpu_op(0, 1, 8'h10, 16'hE003, rd, ntx, nwr);
    chk("R4 local", ntx, 0);
    io_op(0, 8'h10, 0, rd, inh);
    chk("R9 inhibit", inh, 1);
    chk("R9 supplied", rd, 16'hE003);
    io_op(0, 8'h10, 0, rd, inh);
    chk("R9 no second inhibit", inh, 0);
    chk("R9 memory updated", rd, 16'hE003);
    cpu_op(0, 1, 8'h10, 16'hE004, rd, ntx, nwr);
    chk("R9 now Valid", nwr, 1);

    // two caches on one memory
    cpu_op(1, 0, 8'h10, 0, rd, ntx, nwr);
    chk("R8 peer read", rd, 16'hE004);
    chk("R8 peer fill", ntx, 1);
    cpu_op(1, 1, 8'h10, 16'hF001, rd, ntx, nwr);
    chk("R3 peer through", nwr, 1);
    cpu_op(0, 0, 8'h10, 0, rd, ntx, nwr);
    chk("R7 peer invalidated", ntx, 1);
    chk("R7 peer data", rd, 16'hF001);

    // R11: snoop write and processor write hit index 0 in the same cycle
    @(negedge clk);
    io_v = 1; io_we = 1; io_a = 8'h10; io_wd = 16'h5555;
    start_cpu(0, 1, 8'h10, 16'h1234);
    @(negedge clk);
    io_v = 0;
    wait_cpu(0, rd, ntx, nwr);
    chk("R11 refill and write", ntx, 2);
    chk("R11 writes", nwr, 1);
    io_op(0, 8'h10, 0, rd, inh);
    chk("R11 final word", rd, 16'h1234);
    chk("R11 no inhibit", inh, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule